// File: doc/BRIEF.md
# Dual-Length SPI Mode-0 Shift Engine

This block is a controller-side serial shift engine with a single shift path that serves two jobs. During memory loading it takes in 12-bit packets: an 8-bit payload and a 4-bit destination index, which a neighbouring decoder separates. During program execution it exchanges single bytes with an external device. A request on `req_send` or `req_read` while the engine is idle starts a transfer. The frame length comes from `init_mode` at that moment: 12 bits when the flag is set, 8 bits when it is clear. The processor holds its program counter for as long as `busy` is high.

The serial clock is the inverted system clock. It is gated so that it toggles only while chip select is active, and it idles low (SPI mode 0). Data leaves the block least significant bit first. It changes on the rising system-clock edge, which is the falling serial-clock edge, so the peripheral samples it on the next serial-clock rise.

In byte mode, `miso` passes through a capture flop clocked on the falling system-clock edge. In load mode that flop is bypassed and `miso` is taken directly at the rising edge. Chip select goes through a one-cycle phase register, so it falls one cycle after the engine has loaded its counter and shift register.

Top module: `spi_xcvr`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `sclk` and `mosi` are 0, `cs_n` is 1 and `rx_frame` is 0.
- R2: A request seen at a rising clock edge while idle raises `busy` after that edge. When `req_send` and `req_read` are both high, the transfer is a send.
- R3: A transfer moves exactly 12 bits when `init_mode` was 1 at the request and 8 bits when it was 0. `busy` stays high for length+1 cycles.
- R4: `cs_n` falls one cycle after `busy` rises. It rises at the same edge at which `busy` falls, and it is low only while `busy` is high.
- R5: `sclk` equals the inverted system clock while `cs_n` is low and the engine is busy, and it is 0 otherwise.
- R6: On a send, bit k of the frame `{zero padding, tx_byte}` is on `mosi` from the (k+1)-th rising edge after the request edge until the next rising edge.
- R7: In byte mode, `miso` is sampled at the falling clock edge of each bit period. The first bit received lands in `rx_frame[0]`, and `rx_frame[11:8]` is 0.
- R8: In load mode, `miso` is sampled at the rising clock edge that ends each bit period, with no capture flop. The first bit received lands in `rx_frame[0]` and all 12 bits are kept.
- R9: `done` is a one-cycle pulse raised at the edge where `busy` falls. `rx_frame` takes its new value at that same edge.
- R10: Requests and changes on `init_mode` or `tx_byte` while busy have no effect on the running transfer's length, timing or data.
- R11: `mosi` is 0 while idle and during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_send | input | 1 | Start a transfer that shifts out `tx_byte` |
| req_read | input | 1 | Start a receive-only transfer |
| init_mode | input | 1 | 1 selects 12-bit load frames with raw `miso`, 0 selects 8-bit byte mode |
| tx_byte | input | 8 | Byte to send, latched at the request |
| rx_frame | output | 12 | Received frame, LSB first, updated when a transfer ends |
| busy | output | 1 | Transfer in progress (processor stall) |
| done | output | 1 | One-cycle end-of-transfer pulse |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle, the bound checker checks how chip select lines up with `busy`, the counter reload for each frame length, the one-per-bit countdown that keeps a transfer running regardless of new requests, the single-cycle `done` pulse and a quiet `mosi` when idle. The bench scenarios are the only way to show the bit order on `mosi` and in `rx_frame`, and the serial-clock gating. They are also the only way to show which clock edge samples `miso` in each mode. In load mode the bench changes `miso` just after the falling edge, so the capture flop and the raw path give different results.

// File: rtl/spi_xcvr_pkg.sv
package spi_xcvr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/spi_bit_counter.sv
// Down-counter of bits left in the current frame; flags the final bit.
module spi_bit_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= '0;
    else if (load)              cnt <= load_val;
    else if (dec && cnt != '0)  cnt <= cnt - ONE;
  end

  assign last = (cnt == ONE);
endmodule

// File: rtl/spi_shift_reg.sv
// Right-shifting frame register: bit 0 leaves, new bit enters at the top.
module spi_shift_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         bit_in,
  output logic [W-1:0] q,
  output logic [W-1:0] nxt
);
  assign nxt = {bit_in, q[W-1:1]};

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= load_val;
    else if (shift) q <= nxt;
  end
endmodule

// File: rtl/spi_rx_capture.sv
// Falling-edge capture of the serial input, with a raw bypass path.
module spi_rx_capture (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic bypass,
  input  logic miso,
  output logic bit_out
);
  logic cap_q;

  always_ff @(negedge clk) begin
    if (rst)         cap_q <= 1'b0;
    else if (enable) cap_q <= miso;
  end

  assign bit_out = bypass ? miso : cap_q;
endmodule

// File: rtl/spi_xcvr.sv
module spi_xcvr
  import spi_xcvr_pkg::*;
#(
  parameter int FRAME_W = 12,
  parameter int BYTE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_send,
  input  logic               req_read,
  input  logic               init_mode,
  input  logic [BYTE_W-1:0]  tx_byte,
  output logic [FRAME_W-1:0] rx_frame,
  output logic               busy,
  output logic               done,
  output logic               sclk,
  output logic               cs_n,
  output logic               mosi,
  input  logic               miso
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam int PAD_W = FRAME_W - BYTE_W;
  localparam logic [CNT_W-1:0] LEN_FRAME = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] LEN_BYTE  = CNT_W'(BYTE_W);

  xfer_state_e        state;
  logic               start, shift_en, finish, last;
  logic               init_q, tx_q, cs_pre, cs_n_q, done_q, rx_bit;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] sh_q, sh_nxt, rx_q, load_word;

  assign start     = (state == ST_IDLE) && (req_send || req_read);
  assign shift_en  = (state == ST_BUSY) && !cs_n_q;
  assign finish    = shift_en && last;
  assign load_word = req_send ? {{PAD_W{1'b0}}, tx_byte} : '0;

  spi_bit_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (init_mode ? LEN_FRAME : LEN_BYTE),
    .dec      (shift_en),
    .cnt      (bit_cnt),
    .last     (last)
  );

  spi_shift_reg #(.W(FRAME_W)) u_sh (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (load_word),
    .shift    (shift_en),
    .bit_in   (rx_bit),
    .q        (sh_q),
    .nxt      (sh_nxt)
  );

  spi_rx_capture u_cap (
    .clk     (clk),
    .rst     (rst),
    .enable  (!cs_n_q),
    .bypass  (init_q),
    .miso    (miso),
    .bit_out (rx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      init_q <= 1'b0;
      tx_q   <= 1'b0;
      cs_pre <= 1'b1;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= finish;
      if (start) begin
        state  <= ST_BUSY;
        init_q <= init_mode;
        tx_q   <= req_send;
        cs_pre <= 1'b0;
      end
      if (finish) begin
        state  <= ST_IDLE;
        cs_pre <= 1'b1;
        cs_n_q <= 1'b1;
        rx_q   <= init_q ? sh_nxt : {{PAD_W{1'b0}}, sh_nxt[FRAME_W-1:PAD_W]};
      end else begin
        cs_n_q <= cs_pre;
      end
    end
  end

  assign busy     = (state == ST_BUSY);
  assign done     = done_q;
  assign cs_n     = cs_n_q;
  assign rx_frame = rx_q;
  assign mosi     = shift_en & tx_q & sh_q[0];
  assign sclk     = shift_en & ~clk;
endmodule

// File: rtl/spi_xcvr_chk.sv
module spi_xcvr_chk #(
  parameter int FRAME_W = 12,
  parameter int BYTE_W  = 8,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             req_send,
  input logic             req_read,
  input logic             init_mode,
  input logic             busy,
  input logic             done,
  input logic             cs_n,
  input logic             mosi,
  input logic [CNT_W-1:0] cnt
);
  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && (req_send || req_read)) |=> busy);

  p_len_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && (req_send || req_read)) |=>
      (cnt == ($past(init_mode) ? CNT_W'(FRAME_W) : CNT_W'(BYTE_W))));

  p_cs_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && cs_n) |=> !cs_n);

  p_cs_in_busy_r4: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> busy);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_end_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt > CNT_W'(1)) |=> busy);

  p_countdown_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !cs_n && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - CNT_W'(1)));

  p_mosi_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mosi);
endmodule

bind spi_xcvr spi_xcvr_chk #(.FRAME_W(FRAME_W), .BYTE_W(BYTE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_send  (req_send),
  .req_read  (req_read),
  .init_mode (init_mode),
  .busy      (busy),
  .done      (done),
  .cs_n      (cs_n),
  .mosi      (mosi),
  .cnt       (bit_cnt)
);

// File: tb/spi_xcvr_test.sv
module spi_xcvr_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_send = 1'b0, req_read = 1'b0, init_mode = 1'b0, miso = 1'b0;
  logic [7:0]  tx_byte = '0;
  logic [11:0] rx_frame;
  logic        busy, done, sclk, cs_n, mosi;

  int checks = 0;
  int errors = 0;

  spi_xcvr uut (
    .clk(clk), .rst(rst), .req_send(req_send), .req_read(req_read),
    .init_mode(init_mode), .tx_byte(tx_byte), .rx_frame(rx_frame),
    .busy(busy), .done(done), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One transfer. poke: disturb the request inputs in the middle of it.
  task automatic run_xfer(input logic snd, input logic rd, input logic init,
                          input logic [7:0] data, input logic [11:0] rx_bits,
                          input logic poke, input string name);
    int n = init ? 12 : 8;
    logic [11:0] tx_word = {4'b0, data};
    logic [11:0] exp_rx = init ? rx_bits : {4'b0, rx_bits[7:0]};
    logic is_send = snd;
    int busy_cycles = 0;
    logic mosi_ok = 1'b1, sclk_ok = 1'b1, cs_ok = 1'b1;
    @(negedge clk);
    req_send = snd; req_read = rd; init_mode = init; tx_byte = data;
    @(negedge clk);                       // request edge E0 has passed
    req_send = 0; req_read = 0;
    #1;
    check(busy === 1'b1, {name, " R2 busy after request"}, busy, 1);
    check(cs_n === 1'b1, {name, " R4 cs_n one cycle late"}, cs_n, 1);
    check(sclk === 1'b0, {name, " R5 sclk quiet before cs"}, sclk, 0);
    if (busy) busy_cycles++;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      if (!init) miso = rx_bits[k];
      @(negedge clk); #1;
      if (busy) busy_cycles++;
      if (cs_n !== 1'b0) cs_ok = 1'b0;
      if (sclk !== 1'b1) sclk_ok = 1'b0;
      if (mosi !== (is_send ? tx_word[k] : 1'b0)) begin
        mosi_ok = 1'b0;
        check(1'b0, {name, (is_send ? " R6" : " R11"), " mosi bit"}, mosi,
              is_send ? tx_word[k] : 1'b0);
      end
      if (init) miso = rx_bits[k];
      if (poke && k == 2) begin
        req_send = 1; req_read = 1; init_mode = ~init; tx_byte = ~data;
      end
      if (poke && k == 3) begin
        req_send = 0; req_read = 0; init_mode = init; tx_byte = data;
      end
    end
    check(cs_ok, {name, " R4 cs_n low during bits"}, cs_ok, 1);
    check(sclk_ok, {name, " R5 sclk high in clock-low phases"}, sclk_ok, 1);
    check(mosi_ok, {name, is_send ? " R6 mosi stream" : " R11 mosi stream"},
          mosi_ok, 1);
    @(posedge clk); #1;                   // final shift edge
    check(busy === 1'b0, {name, " R3 busy ends after length"}, busy, 0);
    check(busy_cycles == n + 1, {name, " R3 busy cycle count"}, busy_cycles, n + 1);
    check(cs_n === 1'b1, {name, " R4 cs_n rises with busy"}, cs_n, 1);
    check(done === 1'b1, {name, " R9 done at end"}, done, 1);
    check(rx_frame === exp_rx,
          {name, init ? " R8 rx_frame load mode" : " R7 rx_frame byte mode"},
          rx_frame, exp_rx);
    @(negedge clk); #1;
    check(sclk === 1'b0, {name, " R5 sclk idle low"}, sclk, 0);
    check(mosi === 1'b0, {name, " R11 mosi idle low"}, mosi, 0);
    @(posedge clk); #1;
    check(done === 1'b0, {name, " R9 done one cycle"}, done, 0);
    if (poke) check(busy === 1'b0, {name, " R10 no restart"}, busy, 0);
    miso = 0;
  endtask

  task automatic test_reset;
    check(busy === 1'b0 && done === 1'b0, "R1 busy/done clear", {busy, done}, 0);
    check(cs_n === 1'b1, "R1 cs_n high", cs_n, 1);
    check(sclk === 1'b0 && mosi === 1'b0, "R1 sclk/mosi low", {sclk, mosi}, 0);
    check(rx_frame === 12'h000, "R1 rx_frame clear", rx_frame, 0);
  endtask

  task automatic test_write;  run_xfer(1, 0, 0, 8'hA5, 12'h000, 0, "write"); endtask
  task automatic test_read;   run_xfer(0, 1, 0, 8'h00, 12'h03C, 0, "read"); endtask
  task automatic test_load;   run_xfer(0, 1, 1, 8'h00, 12'hB7E, 0, "load"); endtask
  task automatic test_load_tx; run_xfer(1, 0, 1, 8'h81, 12'h5A3, 0, "load_tx"); endtask
  task automatic test_ignore; run_xfer(0, 1, 0, 8'h00, 12'h0C9, 1, "ignore"); endtask
  task automatic test_both;   run_xfer(1, 1, 0, 8'h6B, 12'h012, 0, "both"); endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk); #1;
    test_reset();
    test_write();
    test_read();
    test_load();
    test_load_tx();
    test_ignore();
    test_both();
    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule